// File: doc/BRIEF.md
# Dual-Timing Multiplexed Bus Slave Port

This block is the byte-wide slave port for a 128-location register and memory space on a shared address/data bus. One mode input decides at run time which strobe rules the pins obey. Under Motorola timing, DS is a positive data strobe and R/W is a level. Under Intel timing, DS is an active-low output enable and R/W is an active-low write enable. An address strobe demultiplexes the bus. Its falling edge captures the location, and its rising edge wipes that location out again.

All strobe, select, mode, power-fail and bus pins pass through a synchronizer into the local clock domain. Every edge is detected on the synchronized samples. Toward the register space the block presents a held address, a one-cycle write pulse with its byte, a one-cycle read pulse, and a bus drive enable with the read byte. A latched address allows exactly one data phase. Chip select, a power-fail input and reset each shut off all access, but address capture still runs while chip select is inactive.

Top module: `mux_bus_slave`

## Requirements
- R1: While `rst_n` is low, `wr_en`, `rd_en` and `ad_oe` are 0, `addr` is 0 and `ad_out` is 0.
- R2: A falling edge on `as_i` loads bits 6:0 of the bus into `addr`. Bit 7 has no effect, so bus value 8'hFF gives `addr` 7'h7F. `addr` holds that value until the next rising edge of `as_i`.
- R3: A rising edge on `as_i` sets `addr` to 0, whether `cs_n` is high or low.
- R4: With `mot`=1, a falling edge on `ds_i` while `rw_i` is low gives exactly one `wr_en` pulse. The pulse carries the latched `addr` and, on `wr_data`, the bus byte held while DS was high.
- R5: With `mot`=1, while `ds_i` and `rw_i` are both high, `ad_oe` is 1 and `ad_out` equals `rd_data`. Exactly one `rd_en` pulse occurs at the start of that window. `ad_oe` returns to 0 after `ds_i` falls.
- R6: With `mot`=0, a rising edge on `rw_i` gives exactly one `wr_en` pulse, carrying the latched `addr` and the bus byte.
- R7: With `mot`=0, while `ds_i` is low and `rw_i` is high, `ad_oe` is 1 and `ad_out` equals `rd_data`, with one `rd_en` pulse. `ad_oe` returns to 0 after `ds_i` rises.
- R8: A data phase with `cs_n` high produces no `wr_en`, no `rd_en` and no `ad_oe`. The address captured before it is still shown on `addr`.
- R9: While `pfail` is high, no `wr_en`, `rd_en` or `ad_oe` occurs.
- R10: Each latched address allows one data phase. A second write or read strobe with no new address strobe in between has no effect.
- R11: Address and data strobes applied while `rst_n` is low cause no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pfail | input | 1 | High while supply is below the power-fail threshold |
| mot | input | 1 | 1 selects Motorola strobe rules, 0 selects Intel rules |
| as_i | input | 1 | Address strobe |
| ds_i | input | 1 | Data strobe (Motorola) or output enable, active low (Intel) |
| rw_i | input | 1 | Read/write level (Motorola) or write enable, active low (Intel) |
| cs_n | input | 1 | Active-low chip select |
| ad_in | input | DATA_W | Bus value seen on the AD pins |
| ad_out | output | DATA_W | Byte to drive onto the AD pins |
| ad_oe | output | 1 | Drive enable for the AD pins |
| addr | output | ADDR_W | Latched location |
| wr_en | output | 1 | One-cycle write pulse |
| wr_data | output | DATA_W | Byte to write |
| rd_en | output | 1 | One-cycle read pulse |
| rd_data | input | DATA_W | Byte returned by the register space for `addr` |

## Verification
The bench builds the port with DATA_W=8, ADDR_W=7 and SYNC_STAGES=3, which is one stage deeper than the default. Each result is therefore sampled after a settle window, not on a fixed cycle. This shows that the write and read behaviour depends only on the order of synchronized edges and not on the synchronizer depth. The 7-bit address makes it possible to reach the top-bit-ignored case and both address extremes, 0 and 7'h7F.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic {
      TIMING_INTEL = 1'b0,
      TIMING_MOTO  = 1'b1
   } timing_e;

   typedef struct packed {
      logic as_l;
      logic ds_l;
      logic rw_l;
      logic csn_l;
      logic pf_l;
      logic mot_l;
   } ctl_pins_t;

   localparam int CTL_W = $bits(ctl_pins_t);
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/mbs_addr_latch.sv
module mbs_addr_latch #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_s,
   input  logic [ADDR_W-1:0] ad_lo,
   input  logic              consume,
   output logic [ADDR_W-1:0] addr,
   output logic              vld
);
   logic as_d;
   logic as_fall, as_rise;

   assign as_fall = as_d & ~as_s;
   assign as_rise = ~as_d & as_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_d <= 1'b0;
         addr <= '0;
         vld  <= 1'b0;
      end else begin
         as_d <= as_s;
         if (as_rise) begin
            addr <= '0;
            vld  <= 1'b0;
         end else if (as_fall) begin
            addr <= ad_lo;
            vld  <= 1'b1;
         end else if (consume) begin
            vld  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mbs_strobe_dec.sv
module mbs_strobe_dec #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mot_s,
   input  logic              ds_s,
   input  logic              rw_s,
   input  logic              csn_s,
   input  logic              pf_s,
   input  logic              vld,
   input  logic [DATA_W-1:0] ad_s,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_en,
   output logic              ad_oe,
   output logic              phase_end
);
   import mbs_pkg::*;

   logic              ds_d, rw_d, drive_d;
   logic [DATA_W-1:0] ad_d;
   logic              wr_edge, drive, granted;

   always_comb begin
      if (timing_e'(mot_s) == TIMING_MOTO) begin
         wr_edge = ds_d & ~ds_s & ~rw_d;
         drive   = ds_s & rw_s;
      end else begin
         wr_edge = ~rw_d & rw_s;
         drive   = ~ds_s & rw_s;
      end
   end

   assign granted   = vld & ~csn_s & ~pf_s;
   assign phase_end = wr_edge | (drive_d & ~drive);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ds_d    <= 1'b0;
         rw_d    <= 1'b0;
         drive_d <= 1'b0;
         ad_d    <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
         rd_en   <= 1'b0;
         ad_oe   <= 1'b0;
      end else begin
         ds_d    <= ds_s;
         rw_d    <= rw_s;
         drive_d <= drive;
         ad_d    <= ad_s;
         wr_en   <= wr_edge & granted;
         if (wr_edge & granted) wr_data <= ad_d;
         rd_en   <= drive & granted & ~ad_oe;
         ad_oe   <= drive & granted;
      end
   end
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pfail,
   input  logic              mot,
   input  logic              as_i,
   input  logic              ds_i,
   input  logic              rw_i,
   input  logic              cs_n,
   input  logic [DATA_W-1:0] ad_in,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_en,
   input  logic [DATA_W-1:0] rd_data
);
   import mbs_pkg::*;

   if (ADDR_W < 1 || ADDR_W >= DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must be at least 1 and below DATA_W");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   ctl_pins_t         pins_raw, pins_s;
   logic [DATA_W-1:0] ad_s;
   logic              addr_vld, phase_end, pf_s;

   assign pins_raw = '{as_l: as_i, ds_l: ds_i, rw_l: rw_i,
                       csn_l: cs_n, pf_l: pfail, mot_l: mot};

   mbs_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));

   mbs_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_ad (
      .clk(clk), .rst_n(rst_n), .d(ad_in), .q(ad_s));

   assign pf_s = pins_s.pf_l;

   mbs_addr_latch #(.ADDR_W(ADDR_W)) u_alat (
      .clk(clk), .rst_n(rst_n), .as_s(pins_s.as_l),
      .ad_lo(ad_s[ADDR_W-1:0]), .consume(phase_end),
      .addr(addr), .vld(addr_vld));

   mbs_strobe_dec #(.DATA_W(DATA_W)) u_sdec (
      .clk(clk), .rst_n(rst_n), .mot_s(pins_s.mot_l), .ds_s(pins_s.ds_l),
      .rw_s(pins_s.rw_l), .csn_s(pins_s.csn_l), .pf_s(pf_s), .vld(addr_vld),
      .ad_s(ad_s), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .ad_oe(ad_oe), .phase_end(phase_end));

   assign ad_out = ad_oe ? rd_data : '0;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              ad_oe,
   input logic [ADDR_W-1:0] addr,
   input logic              pf_s,
   input logic              vld
);
   always @(posedge clk)
      if (!rst_n) AST_RST_IDLE: assert (!wr_en && !rd_en && !ad_oe && addr == '0); // R1

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !wr_en); // R4
   AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> ad_oe); // R5
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> !rd_en); // R7
   AST_PF_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      pf_s |=> (!wr_en && !rd_en && !ad_oe)); // R9
   AST_WR_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(vld)); // R10
endmodule

bind mux_bus_slave mbs_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ad_oe(ad_oe),
   .addr(addr), .pf_s(pf_s), .vld(addr_vld));

// File: tb/sim_mux_bus_slave.sv
module sim_mux_bus_slave;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int AW = 7;
   localparam int SETTLE = 8;

   logic clk = 0, rst_n = 0, pfail = 0, mot = 1, as_i = 0, ds_i = 0, rw_i = 1, cs_n = 1;
   logic [DW-1:0] ad_in = '0, ad_out, wr_data, rd_data;
   logic [AW-1:0] addr;
   logic ad_oe, wr_en, rd_en;

   int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
   logic [AW-1:0] last_a;
   logic [DW-1:0] last_d;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mux_bus_slave #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(3)) u0 (
      .clk(clk), .rst_n(rst_n), .pfail(pfail), .mot(mot), .as_i(as_i), .ds_i(ds_i),
      .rw_i(rw_i), .cs_n(cs_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

   function automatic logic [DW-1:0] mem_model(input logic [AW-1:0] a);
      return {a[3:0], a[6:3]} ^ 8'hA5;
   endfunction
   assign rd_data = mem_model(addr);

   always @(posedge clk) begin
      if (wr_en) begin wr_cnt <= wr_cnt + 1; last_a <= addr; last_d <= wr_data; end
      if (rd_en) rd_cnt <= rd_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_mode(input logic m);
      ds_i = m ? 1'b0 : 1'b1; rw_i = 1'b1; settle();
      mot = m; settle();
   endtask

   task automatic addr_phase(input logic [DW-1:0] a);
      ad_in = a; as_i = 1; settle();
      as_i = 0; settle();
   endtask

   task automatic do_write(input logic [DW-1:0] d);
      ad_in = d;
      if (mot) begin
         rw_i = 0; ds_i = 1; settle(); ds_i = 0; settle(); rw_i = 1; settle();
      end else begin
         rw_i = 0; settle(); rw_i = 1; settle();
      end
   endtask

   // read: returns oe/data seen mid-window and oe after release
   task automatic do_read(output logic oe_mid, output logic [DW-1:0] d_mid, output logic oe_end);
      rw_i = 1;
      ds_i = mot ? 1'b1 : 1'b0; settle();
      oe_mid = ad_oe; d_mid = ad_out;
      ds_i = mot ? 1'b0 : 1'b1; settle();
      oe_end = ad_oe;
   endtask

   typedef struct packed {
      logic mt; logic csn; logic wr; logic [7:0] a; logic [7:0] d;
   } vec_t;
   localparam vec_t VECS [8] = '{
      '{1'b1, 1'b0, 1'b1, 8'h12, 8'h3C},
      '{1'b1, 1'b0, 1'b0, 8'h45, 8'h00},
      '{1'b0, 1'b0, 1'b1, 8'h7F, 8'hA1},
      '{1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
      '{1'b1, 1'b1, 1'b1, 8'h33, 8'h55},
      '{1'b0, 1'b1, 1'b0, 8'h2A, 8'h00},
      '{1'b0, 1'b0, 1'b1, 8'hFF, 8'h0F},
      '{1'b1, 1'b0, 1'b0, 8'h80, 8'h00}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic oe_m, oe_e;
      logic [DW-1:0] dm;
      int wc, rc;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(!wr_en && !rd_en && !ad_oe && addr == 0 && ad_out == 0, "R1", {wr_en, rd_en, ad_oe}, 0);
      // R11 strobes during reset do nothing
      cs_n = 0; addr_phase(8'h21);
      chk(addr == 0, "R11 addr", addr, 0);
      wc = wr_cnt; do_write(8'h99);
      chk(wr_cnt == wc, "R11 write", wr_cnt - wc, 0);
      do_read(oe_m, dm, oe_e);
      chk(!oe_m, "R11 read", oe_m, 0);
      rst_n = 1; settle();

      foreach (VECS[i]) begin
         vec_t v = VECS[i];
         logic acc = ~v.csn;
         set_mode(v.mt);
         cs_n = v.csn;
         addr_phase(v.a);
         chk(addr == v.a[6:0], "R2 addr latch", addr, v.a[6:0]);
         wc = wr_cnt; rc = rd_cnt;
         if (v.wr) begin
            do_write(v.d);
            chk(wr_cnt - wc == int'(acc), v.mt ? "R4 R8 wr count" : "R6 R8 wr count", wr_cnt - wc, acc);
            if (acc) chk(last_a == v.a[6:0] && last_d == v.d, v.mt ? "R4 wr addr/data" : "R6 wr addr/data",
                         {last_a, last_d}, {v.a[6:0], v.d});
         end else begin
            do_read(oe_m, dm, oe_e);
            chk(oe_m == acc, v.mt ? "R5 R8 oe" : "R7 R8 oe", oe_m, acc);
            if (acc) chk(dm == mem_model(v.a[6:0]), v.mt ? "R5 data" : "R7 data", dm, mem_model(v.a[6:0]));
            chk(!oe_e, v.mt ? "R5 release" : "R7 release", oe_e, 0);
            chk(rd_cnt - rc == int'(acc), "R5 R7 rd count", rd_cnt - rc, acc);
         end
         if (!acc) chk(addr == v.a[6:0], "R8 addr kept", addr, v.a[6:0]);
      end

      // R3 AS rise clears with CS inactive
      set_mode(1'b0); cs_n = 1;
      addr_phase(8'h15);
      ad_in = 8'h00; as_i = 1; settle();
      chk(addr == 0, "R3 clear", addr, 0);
      as_i = 0; settle();

      // R10 second strobe without new address
      cs_n = 0; addr_phase(8'h22);
      wc = wr_cnt; do_write(8'h11);
      chk(wr_cnt - wc == 1, "R10 first write", wr_cnt - wc, 1);
      do_write(8'h77);
      chk(wr_cnt - wc == 1, "R10 repeat write", wr_cnt - wc, 1);
      chk(last_d == 8'h11, "R10 data kept", last_d, 8'h11);
      set_mode(1'b1); addr_phase(8'h05);
      do_read(oe_m, dm, oe_e);
      do_read(oe_m, dm, oe_e);
      chk(!oe_m, "R10 repeat read", oe_m, 0);

      // R9 power fail blocks access
      pfail = 1; settle();
      addr_phase(8'h0A);
      wc = wr_cnt; do_write(8'h66);
      chk(wr_cnt == wc, "R9 write", wr_cnt - wc, 0);
      addr_phase(8'h0B);
      do_read(oe_m, dm, oe_e);
      chk(!oe_m, "R9 read", oe_m, 0);
      pfail = 0; settle();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule